// File: doc/BRIEF.md
# OTP Byte Programming Sequencer

This block drives the programming of a one-time-programmable array, one byte at a time. A start strobe raises the high-voltage enable and points the address counter at location zero. For each byte the block applies a program pulse of a fixed number of clock cycles, then reads the byte back under high voltage. If the read-back matches the source data, the block moves to the next address. If it does not match, the block pulses the byte again. It gives up once a byte has taken the maximum number of pulses without a match.

After the last address has been programmed, the high voltage is dropped. The block then reads the whole range again from location zero at the normal supply level and compares each byte with the source. It stops at the first mismatch. Done and pass/fail stay held until the next start. The array, the source data and the supply switching sit outside the block. The source byte is taken combinationally for the current address.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, hv_en_o, pgm_o and rd_o are all 0.
- R2: A start strobe while idle clears done_o and pass_o, raises hv_en_o and busy_o, and makes the first program pulse at address 0.
- R3: Every program pulse holds pgm_o high for exactly PULSE_CYC consecutive cycles, with hv_en_o high and mem_wdata_o equal to src_data_i for the current address.
- R4: The cycle after each pulse ends, rd_o is high for one cycle with hv_en_o still high. mem_rdata_i is compared in the following cycle.
- R5: The retry count is cleared for each new byte and counts pulses. A byte that still mismatches after its MAX_TRY-th pulse ends the run with done_o=1, pass_o=0 and hv_en_o=0, and no further pulse follows.
- R6: A matching verify stops pulsing that byte and moves to the next address. Addresses are programmed in ascending order up to last_addr_i.
- R7: After the last byte verifies, hv_en_o goes low. Every address from 0 to last_addr_i is then read once, in ascending order, with no program pulse.
- R8: The final compare sets pass_o=1 only if every byte read at normal voltage equals its source byte. The first mismatch ends the run with pass_o=0.
- R9: done_o and pass_o hold their values until the next start. A start strobe while busy_o is high has no effect on the run.
- R10: pgm_o and rd_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| last_addr_i | input | AW | Highest address to program |
| src_data_i | input | DW | Source byte for mem_addr_o |
| mem_rdata_i | input | DW | Array read data, valid one cycle after rd_o |
| mem_addr_o | output | AW | Array address |
| mem_wdata_o | output | DW | Byte being programmed |
| pgm_o | output | 1 | Program pulse (write, high voltage) |
| rd_o | output | 1 | Read strobe (verify or final compare) |
| hv_en_o | output | 1 | Programming voltage enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished, held |
| pass_o | output | 1 | Result, valid while done_o is high |

## Verification
The assertions assume that start_i is a single-cycle strobe and that last_addr_i and src_data_i are stable for the whole run. The bench changes source data and last address only while the block is idle. Its array model returns read data one cycle after rd_o. Programming behaviour is varied per byte through a random count of pulses needed (from 1 to one past the retry limit) and an occasional marginal cell that reads wrong only at normal voltage. Source bytes never equal the erased value, so every byte really needs its pulses.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_VRD,
    ST_VCHK,
    ST_CRD,
    ST_CCHK
  } seq_state_e;
endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PULSE_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = $clog2(PULSE_CYC) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = run_i && (cnt_q == CW'(PULSE_CYC - 1));

  // R3
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CW'(PULSE_CYC)));
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRY = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);
  localparam int TW = $clog2(MAX_TRY + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + TW'(1);
  end

  assign at_max_o = (cnt_q == TW'(MAX_TRY));

  // R5
  try_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(MAX_TRY));
endmodule

// File: rtl/otp_addr_counter.sv
module otp_addr_counter #(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (clr_i) addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PULSE_CYC = 4000,
  parameter int MAX_TRY   = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] last_addr_i,
  input  logic [DW-1:0] src_data_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pgm_o,
  output logic          rd_o,
  output logic          hv_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);
  seq_state_e st_q, st_d;
  logic hv_q, hv_d, done_q, done_d, pass_q, pass_d;
  logic pulse_last, try_at_max;
  logic try_clr, try_inc, addr_clr, addr_inc;
  logic match, at_last;

  otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_PULSE),
    .last_o (pulse_last)
  );

  otp_try_counter #(.MAX_TRY(MAX_TRY)) i_try (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (try_clr),
    .inc_i    (try_inc),
    .at_max_o (try_at_max)
  );

  otp_addr_counter #(.AW(AW)) i_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_clr),
    .inc_i  (addr_inc),
    .addr_o (mem_addr_o)
  );

  assign match   = (mem_rdata_i == src_data_i);
  assign at_last = (mem_addr_o == last_addr_i);

  always_comb begin
    st_d     = st_q;
    hv_d     = hv_q;
    done_d   = done_q;
    pass_d   = pass_q;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d     = ST_PULSE;
        hv_d     = 1'b1;
        done_d   = 1'b0;
        pass_d   = 1'b0;
        addr_clr = 1'b1;
        try_clr  = 1'b1;
      end
      ST_PULSE: if (pulse_last) begin
        try_inc = 1'b1;
        st_d    = ST_VRD;
      end
      ST_VRD: st_d = ST_VCHK;
      ST_VCHK: begin
        if (match) begin
          if (at_last) begin
            st_d     = ST_CRD;
            hv_d     = 1'b0;
            addr_clr = 1'b1;
          end else begin
            st_d     = ST_PULSE;
            addr_inc = 1'b1;
            try_clr  = 1'b1;
          end
        end else if (try_at_max) begin
          st_d   = ST_IDLE;
          hv_d   = 1'b0;
          done_d = 1'b1;
          pass_d = 1'b0;
        end else begin
          st_d = ST_PULSE;
        end
      end
      ST_CRD: st_d = ST_CCHK;
      ST_CCHK: begin
        if (!match) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          pass_d = 1'b0;
        end else if (at_last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          pass_d = 1'b1;
        end else begin
          st_d     = ST_CRD;
          addr_inc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hv_q   <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hv_q   <= hv_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign mem_wdata_o = src_data_i;
  assign pgm_o       = (st_q == ST_PULSE);
  assign rd_o        = (st_q == ST_VRD) || (st_q == ST_CRD);
  assign hv_en_o     = hv_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign pass_o      = pass_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pgm_o && rd_o));

  // R3
  pgm_hv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_o |-> hv_en_o);

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgm_o) |-> $past(pulse_last));

  // R4
  verify_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgm_o) |-> (rd_o && hv_en_o));

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (mem_addr_o != $past(mem_addr_o)))
      |-> ((mem_addr_o == AW'($past(mem_addr_o) + AW'(1))) || (mem_addr_o == '0)));
endmodule

// File: tb/test_otp_prog_seq.sv
module test_otp_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int PULSE = 5;
  localparam int TRIES = 10;
  localparam int NA    = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [AW-1:0] last_addr_i = '0;
  logic [DW-1:0] src_data_i, mem_rdata_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic pgm_o, rd_o, hv_en_o, busy_o, done_o, pass_o;

  otp_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .MAX_TRY(TRIES)) i_otp_prog_seq (
    .clk_i, .rst_ni, .start_i, .last_addr_i, .src_data_i, .mem_rdata_i,
    .mem_addr_o, .mem_wdata_o, .pgm_o, .rd_o, .hv_en_o, .busy_o, .done_o, .pass_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [DW-1:0] mem_a [NA];
  logic [DW-1:0] src_a [NA];
  int            need_a[NA];
  bit            marg_a[NA];
  int            pcnt_a[NA];
  logic          pgm_d = 1'b0;

  assign src_data_i = src_a[mem_addr_o];

  // array model: a byte takes its value once it has seen need_a pulses
  always @(posedge clk_i) begin
    pgm_d <= pgm_o;
    if (pgm_o && !pgm_d) begin
      pcnt_a[mem_addr_o] = pcnt_a[mem_addr_o] + 1;
      if (pcnt_a[mem_addr_o] >= need_a[mem_addr_o]) mem_a[mem_addr_o] = mem_wdata_o;
    end
    if (rd_o)
      mem_rdata_i <= (marg_a[mem_addr_o] && !hv_en_o) ? (mem_a[mem_addr_o] ^ 8'h01)
                                                      : mem_a[mem_addr_o];
  end

  int n_chk = 0, n_fail = 0;
  int run_len, pulses, hi_reads, lo_reads, first_addr, last_pa;
  int bad3, bad4, bad6, bad7, bad10;

  always @(negedge clk_i) if (rst_ni) begin
    if (pgm_o && rd_o) bad10++;
    if (pgm_o) begin
      if (run_len == 0) begin
        pulses++;
        if (first_addr < 0) first_addr = int'(mem_addr_o);
        if (int'(mem_addr_o) < last_pa) bad6++;
        last_pa = int'(mem_addr_o);
      end
      run_len++;
      if (!hv_en_o || mem_wdata_o != src_a[mem_addr_o]) bad3++;
    end else if (run_len != 0) begin
      if (run_len != PULSE) bad3++;
      if (!rd_o || !hv_en_o) bad4++;
      run_len = 0;
    end
    if (rd_o && hv_en_o) hi_reads++;
    if (rd_o && !hv_en_o) begin
      if (int'(mem_addr_o) != lo_reads) bad7++;
      lo_reads++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int last, input int need_all);
    for (int a = 0; a < NA; a++) begin
      src_a[a]  = DW'($urandom_range(0, 254));
      mem_a[a]  = '1;
      need_a[a] = (need_all > 0) ? need_all : int'($urandom_range(1, 10));
      if (need_all == 0 && $urandom_range(0, 9) == 0) need_a[a] = TRIES + 1;
      marg_a[a] = (need_all == 0) && ($urandom_range(0, 11) == 0);
      pcnt_a[a] = 0;
    end
    last_addr_i = AW'(last);
  endtask

  function automatic void expect_run(input int last, output int e_pulses, output int e_lo, output bit e_pass);
    e_pulses = 0; e_lo = 0; e_pass = 1'b1;
    for (int a = 0; a <= last; a++) begin
      e_pulses += (need_a[a] > TRIES) ? TRIES : need_a[a];
      if (need_a[a] > TRIES) begin e_pass = 1'b0; return; end
    end
    for (int a = 0; a <= last; a++) begin
      e_lo++;
      if (marg_a[a]) begin e_pass = 1'b0; return; end
    end
  endfunction

  bit hung = 1'b0;

  task automatic run_case(input bit poke);
    int e_pulses, e_lo, cyc;
    bit e_pass;
    logic d0, p0;
    expect_run(int'(last_addr_i), e_pulses, e_lo, e_pass);
    run_len = 0; pulses = 0; hi_reads = 0; lo_reads = 0; first_addr = -1; last_pa = -1;
    bad3 = 0; bad4 = 0; bad6 = 0; bad7 = 0; bad10 = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(busy_o && !done_o && hv_en_o, "R2", "busy/hv after start", int'(busy_o), 1);
    cyc = 0;
    while (!(done_o && !busy_o) && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      if (poke && cyc == 30 && busy_o) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    if (cyc >= 5000) begin
      hung = 1'b1;
      chk(1'b0, "R9", "run timeout", cyc, 5000);
      return;
    end
    chk(done_o == 1'b1, "R9", "done", int'(done_o), 1);
    chk(pass_o == e_pass, "R8", "pass", int'(pass_o), int'(e_pass));
    chk(pulses == e_pulses, "R5", "pulse total (R9 start while busy)", pulses, e_pulses);
    chk(hi_reads == pulses, "R4", "verify reads", hi_reads, pulses);
    chk(lo_reads == e_lo, "R7", "normal-voltage reads", lo_reads, e_lo);
    chk(bad3 == 0, "R3", "pulse width/data/hv errors", bad3, 0);
    chk(bad4 == 0, "R4", "verify not after pulse", bad4, 0);
    chk(bad6 == 0 && bad7 == 0, "R6", "address order errors", bad6 + bad7, 0);
    chk(bad10 == 0, "R10", "overlapping strobes", bad10, 0);
    chk(first_addr == 0, "R2", "first pulse address", first_addr, 0);
    chk(!hv_en_o, "R7", "hv after run", int'(hv_en_o), 0);
    d0 = done_o; p0 = pass_o;
    repeat (20) @(negedge clk_i);
    chk(done_o == d0 && pass_o == p0 && !busy_o && !pgm_o && !rd_o, "R9", "result held", int'(pass_o), int'(p0));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !pass_o && !hv_en_o && !pgm_o && !rd_o, "R1", "reset outputs",
        int'({busy_o, done_o, pass_o, hv_en_o, pgm_o, rd_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // all bytes take on the first pulse
    prep(7, 1);                                if (!hung) run_case(1'b0);
    // one byte needs exactly the retry limit
    prep(5, 3); need_a[2] = TRIES;             if (!hung) run_case(1'b0);
    // one byte never takes
    prep(5, 2); need_a[3] = TRIES + 1;         if (!hung) run_case(1'b0);
    // marginal cell at the last address, seen only at normal voltage
    prep(6, 1); marg_a[6] = 1'b1;              if (!hung) run_case(1'b0);
    // single byte range
    prep(0, 2);                                if (!hung) run_case(1'b0);
    // full range, start strobe while busy (R9)
    prep(NA - 1, 4);                           if (!hung) run_case(1'b1);
    for (int i = 0; i < 8; i++) begin
      prep(int'($urandom_range(0, NA - 1)), 0);
      if (!hung) run_case(i[0]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule